// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from a parameterised number of device lines and presents one interrupt at a time to a processor. Each request line passes through a two-stage synchroniser. A rising edge on the synchronised line then records a pending request for that line. When no interrupt is outstanding, the controller picks the lowest-numbered line that is both pending and enabled. It forms the vector as the line number plus a programmable base, latches that vector and raises its single interrupt output.

The processor reads the latched vector over a small register bus and writes the acknowledge register when it has taken the interrupt. The acknowledge drops the interrupt output and clears the pending flag of the serviced line only. Other pending lines then compete again. A per-line enable mask holds a request back without losing it: a request raised on a disabled line is delivered once its enable bit is set again.

Register offsets: 0 reads the latched vector; 1 is the acknowledge (write only, reads 0); 2 is the vector base (read/write, bits [2:0] always zero); 3 is the enable mask (bit n enables line n, 1 = enabled).

Top module: `vpic_top`

## Requirements
- R1: When several lines are pending and enabled at the moment of selection, the lowest-indexed one is delivered first, and the others follow in ascending index order on later acknowledges.
- R2: The vector equals the vector base plus the line index, computed from the base in force when the vector is latched; after reset the base is 32, so line n yields n + 32.
- R3: A write to offset 2 sets the vector base with its three low bits forced to zero, and reading offset 2 returns the stored value.
- R4: Reading offset 0 returns the latched vector, which stays unchanged while the interrupt is outstanding even if the base is rewritten or new requests arrive.
- R5: Once raised, the interrupt output stays high for as long as no acknowledge is written, however long that is.
- R6: A write to offset 1 while the interrupt is outstanding lowers the output on the next clock edge; a write to offset 1 while no interrupt is outstanding has no effect.
- R7: A request is recognised on the rising edge of its line: with nothing outstanding, the output goes high on the fourth clock edge after the line rises, and a line that stays high after being serviced does not raise a second interrupt.
- R8: A line whose enable bit at offset 3 is 0 never causes the interrupt output to rise, and offset 3 reads back the mask as written.
- R9: A request raised on a disabled line stays pending and is delivered, with its own vector, as soon as its enable bit is set to 1.
- R10: After reset the interrupt output is low, offset 0 reads 0, offset 2 reads 32 and offset 3 reads all lines enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_LINES | Device request lines, asynchronous to clk |
| bus_sel_i | input | 1 | Register bus select |
| bus_wr_i | input | 1 | Register bus write strobe (with select) |
| bus_addr_i | input | 2 | Register offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register |
| irq_o | output | 1 | Interrupt output to the processor |

## Verification
The hardest situation to reach from the ports is a new request plus a base rewrite while a vector is already outstanding. In that situation the latched vector must not move, and the new request must later appear with the new base. The bench gets there by leaving one interrupt unacknowledged. While it waits, it rewrites the base and pulses a lower-numbered line. It then reads the vector, acknowledges, and expects the queued line's vector to come out computed from the new base. Masked-then-enabled delivery and a line held high across its acknowledge are driven the same way, by staging the inputs while the output is busy.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

   typedef enum logic [1:0] {
      REG_VECTOR = 2'd0,
      REG_ACK    = 2'd1,
      REG_BASE   = 2'd2,
      REG_MASK   = 2'd3
   } vpic_reg_e;

   localparam int unsigned BASE_ALIGN_BITS = 3;

endpackage

// File: rtl/vpic_sync.sv
module vpic_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("vpic_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < int'(STAGES); k++) begin
            stage_q[k] <= '0;
         end
      end else begin
         stage_q[0] <= async_i;
         for (int k = 1; k < int'(STAGES); k++) begin
            stage_q[k] <= stage_q[k-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/vpic_pending.sv
module vpic_pending #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned IDX_W     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] level_i,
   input  logic                 clr_en_i,
   input  logic [IDX_W-1:0]     clr_idx_i,
   output logic [NUM_LINES-1:0] pend_o
);

   logic [NUM_LINES-1:0] level_d;
   logic [NUM_LINES-1:0] rise;
   logic [NUM_LINES-1:0] clr_mask;
   logic [NUM_LINES-1:0] pend_q;

   assign rise = level_i & ~level_d;

   genvar g;
   generate
      for (g = 0; g < int'(NUM_LINES); g++) begin : g_clr
         assign clr_mask[g] = clr_en_i && (clr_idx_i == IDX_W'(g));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_d <= '0;
         pend_q  <= '0;
      end else begin
         level_d <= level_i;
         // a fresh edge on the line being cleared is kept
         pend_q  <= (pend_q & ~clr_mask) | rise;
      end
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned IDX_W     = 3
) (
   input  logic [NUM_LINES-1:0] cand_i,
   output logic                 valid_o,
   output logic [IDX_W-1:0]     idx_o
);

   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      // scan downwards so the lowest set index is the last one written
      for (int i = int'(NUM_LINES) - 1; i >= 0; i--) begin
         if (cand_i[i]) begin
            valid_o = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/vpic_regs.sv
module vpic_regs
   import vpic_pkg::*;
#(
   parameter int unsigned NUM_LINES  = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned RESET_BASE = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel_i,
   input  logic                 wr_i,
   input  logic [1:0]           addr_i,
   input  logic [DATA_W-1:0]    wdata_i,
   output logic [DATA_W-1:0]    rdata_o,
   input  logic [VEC_W-1:0]     vec_i,
   output logic                 ack_stb_o,
   output logic [VEC_W-1:0]     base_o,
   output logic [NUM_LINES-1:0] en_o
);

   localparam logic [VEC_W-1:0] ALIGN_MASK = ~VEC_W'((1 << BASE_ALIGN_BITS) - 1);

   logic [VEC_W-1:0]     base_q;
   logic [NUM_LINES-1:0] en_q;
   logic                 wr_stb;

   assign wr_stb    = sel_i && wr_i;
   assign ack_stb_o = wr_stb && (addr_i == REG_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= VEC_W'(RESET_BASE);
         en_q   <= '1;
      end else if (wr_stb) begin
         if (addr_i == REG_BASE) begin
            base_q <= wdata_i[VEC_W-1:0] & ALIGN_MASK;
         end
         if (addr_i == REG_MASK) begin
            en_q <= wdata_i[NUM_LINES-1:0];
         end
      end
   end

   always_comb begin
      unique case (addr_i)
         REG_VECTOR: rdata_o = DATA_W'(vec_i);
         REG_ACK:    rdata_o = '0;
         REG_BASE:   rdata_o = DATA_W'(base_q);
         REG_MASK:   rdata_o = DATA_W'(en_q);
         default:    rdata_o = '0;
      endcase
   end

   assign base_o = base_q;
   assign en_o   = en_q;

endmodule

// File: rtl/vpic_top.sv
module vpic_top #(
   parameter int unsigned NUM_LINES   = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned RESET_BASE  = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] req_i,
   input  logic                 bus_sel_i,
   input  logic                 bus_wr_i,
   input  logic [1:0]           bus_addr_i,
   input  logic [DATA_W-1:0]    bus_wdata_i,
   output logic [DATA_W-1:0]    bus_rdata_o,
   output logic                 irq_o
);

   localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   generate
      if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
         $error("vpic_top: NUM_LINES must be 1..DATA_W");
      end
      if (VEC_W > DATA_W || VEC_W < 4) begin : g_bad_vec
         $error("vpic_top: VEC_W must be 4..DATA_W");
      end
      if ((RESET_BASE % 8) != 0 || RESET_BASE >= (1 << VEC_W)) begin : g_bad_base
         $error("vpic_top: RESET_BASE must be 8-aligned and fit VEC_W");
      end
   endgenerate

   logic [NUM_LINES-1:0] req_s;
   logic [NUM_LINES-1:0] pend_q;
   logic [NUM_LINES-1:0] en_q;
   logic [VEC_W-1:0]     base_q;
   logic                 ack_stb;
   logic                 arb_valid;
   logic [IDX_W-1:0]     arb_idx;
   logic                 irq_q;
   logic [VEC_W-1:0]     vec_q;
   logic [IDX_W-1:0]     idx_q;

   vpic_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (req_i),
      .sync_o  (req_s)
   );

   vpic_pending #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) pend_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .level_i   (req_s),
      .clr_en_i  (irq_q && ack_stb),
      .clr_idx_i (idx_q),
      .pend_o    (pend_q)
   );

   vpic_arb #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) arb_i (
      .cand_i  (pend_q & en_q),
      .valid_o (arb_valid),
      .idx_o   (arb_idx)
   );

   vpic_regs #(
      .NUM_LINES (NUM_LINES),
      .DATA_W    (DATA_W),
      .VEC_W     (VEC_W),
      .RESET_BASE(RESET_BASE)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (bus_sel_i),
      .wr_i      (bus_wr_i),
      .addr_i    (bus_addr_i),
      .wdata_i   (bus_wdata_i),
      .rdata_o   (bus_rdata_o),
      .vec_i     (vec_q),
      .ack_stb_o (ack_stb),
      .base_o    (base_q),
      .en_o      (en_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         vec_q <= '0;
         idx_q <= '0;
      end else if (irq_q) begin
         if (ack_stb) begin
            irq_q <= 1'b0;
         end
      end else if (arb_valid) begin
         irq_q <= 1'b1;
         vec_q <= base_q + VEC_W'(arb_idx);
         idx_q <= arb_idx;
      end
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/vpic_checker.sv
module vpic_checker #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned IDX_W     = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 irq_o,
   input logic                 ack_stb,
   input logic [VEC_W-1:0]     vec_q,
   input logic [IDX_W-1:0]     idx_q,
   input logic [VEC_W-1:0]     base_q,
   input logic [NUM_LINES-1:0] en_q,
   input logic [NUM_LINES-1:0] pend_q
);

   logic [NUM_LINES-1:0] pend_d;
   logic [NUM_LINES-1:0] en_d;
   logic [VEC_W-1:0]     base_d;
   logic [NUM_LINES-1:0] below_m;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_d <= '0;
         en_d   <= '1;
         base_d <= '0;
      end else begin
         pend_d <= pend_q;
         en_d   <= en_q;
         base_d <= base_q;
      end
   end

   always_comb begin
      for (int i = 0; i < int'(NUM_LINES); i++) begin
         below_m[i] = (i < int'(idx_q));
      end
   end

   // R1: no lower-indexed candidate existed when this line was chosen
   a_r1_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ((pend_d & en_d & below_m) == '0));

   // R2: vector is base plus line index, from the base at selection time
   a_r2_vector_sum: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> (vec_q == base_d + VEC_W'(idx_q)));

   // R4: latched vector does not move while outstanding
   a_r4_vector_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack_stb) |=> $stable(vec_q));

   // R5: output held until acknowledged
   a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack_stb) |=> irq_o);

   // R6: acknowledge lowers the output on the next edge
   a_r6_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && ack_stb) |=> !irq_o);

   // R8: only an enabled, pending line can be delivered
   a_r8_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> (en_d[idx_q] && pend_d[idx_q]));

endmodule

bind vpic_top vpic_checker #(
   .NUM_LINES (NUM_LINES),
   .VEC_W     (VEC_W),
   .IDX_W     (IDX_W)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_o   (irq_o),
   .ack_stb (ack_stb),
   .vec_q   (vec_q),
   .idx_q   (idx_q),
   .base_q  (base_q),
   .en_q    (en_q),
   .pend_q  (pend_q)
);

// File: tb/vpic_top_tb_top.sv
module vpic_top_tb_top;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic         sel = 1'b0;
   logic         wr = 1'b0;
   logic [1:0]   addr = '0;
   logic [7:0]   wdata = '0;
   logic [7:0]   rdata;
   logic         irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;
   int exp_q[$];

   always #4 clk = ~clk;

   vpic_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req),
      .bus_sel_i  (sel),
      .bus_wr_i   (wr),
      .bus_addr_i (addr),
      .bus_wdata_i(wdata),
      .bus_rdata_o(rdata),
      .irq_o      (irq)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic bus_write(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_read(logic [1:0] a, output int d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a;
      #1;
      d = int'(rdata);
      sel = 1'b0;
   endtask

   task automatic pulse(logic [N-1:0] lines);
      @(negedge clk);
      req = req | lines;
      repeat (3) @(negedge clk);
      req = req & ~lines;
   endtask

   task automatic wait_irq(output bit seen);
      seen = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (irq) begin
            seen = 1;
            break;
         end
      end
   endtask

   // scoreboard monitor: pops each expected vector as the design delivers it
   task automatic serve_all(string tag);
      int got;
      bit seen;
      while (exp_q.size() > 0) begin
         int want = exp_q.pop_front();
         wait_irq(seen);
         chk({tag, " irq raised"}, int'(seen), 1);
         bus_read(2'd0, got);
         chk({tag, " vector"}, got, want);
         bus_write(2'd1, 8'h00);
         chk({tag, " R6 irq cleared by ack"}, int'(irq), 0);
      end
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      int d;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      chk("R10 irq after reset", int'(irq), 0);
      bus_read(2'd0, d); chk("R10 vector after reset", d, 0);
      bus_read(2'd2, d); chk("R10 R2 base after reset", d, 32);
      bus_read(2'd3, d); chk("R10 mask after reset", d, 255);
      bus_read(2'd1, d); chk("R10 ack reads zero", d, 0);

      // R7 latency: output rises on the fourth edge after the line rises
      @(negedge clk);
      req[3] = 1'b1;
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         chk("R7 irq not yet", int'(irq), 0);
      end
      @(negedge clk);
      chk("R7 irq on fourth edge", int'(irq), 1);
      req[3] = 1'b0;
      // R5 hold without acknowledge
      repeat (12) @(negedge clk);
      chk("R5 irq held", int'(irq), 1);
      bus_read(2'd0, d); chk("R2 R4 vector line 3", d, 35);
      bus_write(2'd1, 8'h00);
      chk("R6 ack clears irq", int'(irq), 0);
      repeat (8) @(negedge clk);
      chk("R6 stays low after ack", int'(irq), 0);

      // R6 acknowledge while idle has no effect
      bus_write(2'd1, 8'h00);
      repeat (4) @(negedge clk);
      chk("R6 idle ack ignored", int'(irq), 0);

      // R1 simultaneous requests, ascending order
      exp_q.push_back(34);
      exp_q.push_back(37);
      exp_q.push_back(38);
      pulse(8'b0110_0100);
      serve_all("R1 priority");

      // R3 base write with low bits forced to zero
      bus_write(2'd2, 8'h45);
      bus_read(2'd2, d); chk("R3 base aligned", d, 8'h40);
      pulse(8'b0000_0010);
      wait_irq(seen);
      chk("R3 irq line 1", int'(seen), 1);
      bus_read(2'd0, d); chk("R3 vector new base", d, 8'h41);

      // R4 vector stable across base rewrite and new lower request
      bus_write(2'd2, 8'h80);
      pulse(8'b0000_0001);
      repeat (6) @(negedge clk);
      bus_read(2'd0, d); chk("R4 vector unchanged", d, 8'h41);
      chk("R4 irq still high", int'(irq), 1);
      bus_write(2'd1, 8'h00);
      chk("R6 ack clears irq", int'(irq), 0);
      exp_q.push_back(8'h80);
      serve_all("R2 R4 queued line 0 with new base");

      // R8 masked line raises nothing
      bus_write(2'd3, 8'hEF);
      bus_read(2'd3, d); chk("R8 mask readback", d, 8'hEF);
      pulse(8'b0001_0000);
      repeat (20) @(negedge clk);
      chk("R8 masked line silent", int'(irq), 0);
      // R9 delivered once enabled
      bus_write(2'd3, 8'hFF);
      exp_q.push_back(8'h84);
      serve_all("R9 pending after enable");

      // R7 level held across acknowledge gives one interrupt only
      @(negedge clk);
      req[2] = 1'b1;
      exp_q.push_back(8'h82);
      serve_all("R7 held line");
      repeat (20) @(negedge clk);
      chk("R7 no retrigger on level", int'(irq), 0);
      req[2] = 1'b0;
      repeat (4) @(negedge clk);

      done = 1;
      summary();
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule